// File: doc/BRIEF.md
# Bank-Select Register with Skip Pass-Through

This block holds the 8-bit file select register of a small core whose instructions are 12 bits wide. It looks at one fetched instruction word per cycle. When the word is the bank-load instruction, a three-bit bank number from the word goes into the bank field of the register. Other bits of the register are not changed.

The block also works out which fetched words a taken conditional skip annuls. A skip that lands on a bank-load does not stop there. It passes through that word, and through any further bank-loads that follow directly, and it annuls the first ordinary word after them. For each word the block raises an annul flag. When the skip ends, it reports how many cycles the whole skip used.

A parameter picks the memory variant, and so which register bits the bank number replaces. A direct write port lets the core set or clear single bits, such as the upper/lower block bit, and this write wins over a bank-load in the same cycle.

Top module: `bank_sel_unit`

## Requirements
- R1: A word is a bank-load only when bits 11:3 equal 9'b0_0000_0011; the bank number is bits 2:0. Any other word, executed without a direct write, leaves `fsr` unchanged.
- R2: With `LARGE_MEM=1` (the default), an executed bank-load puts the bank number into `fsr[6:4]`; bits 7 and 3:0 keep their values. Bank number 3'b111 gives `fsr[6:4]=3'b111`.
- R3: With `LARGE_MEM=0`, an executed bank-load puts the bank number into `fsr[7:5]`; bits 4:0 keep their values.
- R4: A bank-load that is not annulled takes one cycle. `annul` stays low for it, `busy` stays low after it, and `fsr` shows the new bank after the next rising edge.
- R5: A valid word fetched with `skip_req` high is annulled (`annul`=1). If it is not a bank-load, the skip ends in that cycle: `skip_done`=1 and `skip_cycles`=2.
- R6: When a skip lands on a bank-load, that word is annulled, `busy` rises, and the next valid word is annulled too. If that next word is not a bank-load, `skip_done`=1 with `skip_cycles`=3.
- R7: When a skip lands on k bank-loads in a row, all k words and the first non-bank word after them are annulled. `skip_cycles` is reported as k+2 and saturates at 2^CYC_W-1.
- R8: An annulled bank-load leaves `fsr` unchanged. Pass-through state clears once a non-bank word is annulled, so a bank-load fetched after that executes normally.
- R9: While `fsr_wr_en` is high, `fsr` takes all 8 bits of `fsr_wr_data` at the next edge, even if a bank-load executes in the same cycle.
- R10: A synchronous active-high `rst` clears `fsr` to 8'h00 and clears `busy`.
- R11: While `instr_vld` is low, `annul` and `skip_done` stay low, the pass-through state holds, and no bank-load takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instr_vld | input | 1 | A fetched word is present this cycle |
| instr | input | 12 | Fetched instruction word |
| skip_req | input | 1 | The preceding conditional skip was taken; this word is its target |
| fsr_wr_en | input | 1 | Direct write of the whole register |
| fsr_wr_data | input | 8 | Data for the direct write |
| fsr | output | 8 | File select register |
| annul | output | 1 | The current word is annulled |
| busy | output | 1 | Skip pass-through is pending over the next valid word |
| skip_done | output | 1 | The skip sequence ends with this word |
| skip_cycles | output | CYC_W | Cycles the skip used, counting the skip itself; valid with `skip_done` |

## Verification
The assertions assume `skip_req` is raised only together with a valid word, and that `instr` and `skip_req` carry no meaning while `instr_vld` is low. The direct write is taken to be the core's own bit set/clear, so it may arrive in any cycle, including during a pass-through. The stimulus changes every input only on the falling clock edge. It raises `skip_req` only with `instr_vld` high, except in one R11 case that checks the flag is ignored without a valid word. Random words are drawn half from the bank-load encoding, so that chains of bank-loads occur often.

// File: rtl/bsel_pkg.sv
package bsel_pkg;

    localparam int INSTR_W = 12;
    localparam int FSR_W   = 8;
    localparam int BANK_W  = 3;

    typedef logic [INSTR_W-1:0] instr_t;
    typedef logic [FSR_W-1:0]   fsr_t;
    typedef logic [BANK_W-1:0]  bank_t;

    // Upper bits of the word that mark a bank-load
    localparam logic [INSTR_W-BANK_W-1:0] BANK_OP_TAG = 9'b0_0000_0011;

    typedef struct packed {
        logic  is_bank;
        bank_t bank;
    } dec_t;

    typedef enum logic {
        TRK_IDLE  = 1'b0,
        TRK_CHAIN = 1'b1
    } trk_state_e;

    function automatic dec_t decode_word(instr_t w);
        dec_t d;
        d.is_bank = (w[INSTR_W-1:BANK_W] == BANK_OP_TAG);
        d.bank    = w[BANK_W-1:0];
        return d;
    endfunction

    // Lowest bit of the bank field for a variant
    function automatic int bank_lsb(bit large_mem);
        return large_mem ? 4 : 5;
    endfunction

    // Bits a bank-load leaves alone
    function automatic fsr_t keep_mask(bit large_mem);
        return large_mem ? 8'h8F : 8'h1F;
    endfunction

endpackage

// File: rtl/bsel_decode.sv
module bsel_decode
    import bsel_pkg::*;
(
    input  instr_t instr_i,
    output dec_t   dec_o
);

    always_comb begin
        dec_o = decode_word(instr_i);
    end

endmodule

// File: rtl/bsel_skip_track.sv
module bsel_skip_track
    import bsel_pkg::*;
#(
    parameter int CYC_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             vld_i,
    input  logic             skip_i,
    input  logic             is_bank_i,
    output logic             annul_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [CYC_W-1:0] cyc_o
);

    localparam logic [CYC_W-1:0] CYC_MAX   = '1;
    localparam logic [CYC_W-1:0] CYC_FIRST = CYC_W'(2);

    trk_state_e       state_q, state_d;
    logic [CYC_W-1:0] cnt_q, cnt_d;
    logic [CYC_W-1:0] cur_cnt;
    logic             in_chain;

    always_comb begin
        in_chain = (state_q == TRK_CHAIN);
        annul_o  = vld_i & (skip_i | in_chain);
        if (in_chain) begin
            cur_cnt = (cnt_q == CYC_MAX) ? cnt_q : cnt_q + 1'b1;
        end else begin
            cur_cnt = CYC_FIRST;
        end
        done_o  = annul_o & ~is_bank_i;
        cyc_o   = done_o ? cur_cnt : '0;
        busy_o  = in_chain;

        state_d = state_q;
        cnt_d   = cnt_q;
        if (annul_o) begin
            if (is_bank_i) begin
                state_d = TRK_CHAIN;
                cnt_d   = cur_cnt;
            end else begin
                state_d = TRK_IDLE;
                cnt_d   = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TRK_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

endmodule

// File: rtl/bsel_fsr_reg.sv
module bsel_fsr_reg
    import bsel_pkg::*;
#(
    parameter bit LARGE_MEM = 1'b1
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en_i,
    input  fsr_t  wr_data_i,
    input  logic  load_i,
    input  bank_t bank_i,
    output fsr_t  fsr_o
);

    fsr_t fsr_q, fsr_d;

    generate
        if (LARGE_MEM) begin : g_large
            localparam int LSB = bank_lsb(1'b1);
            always_comb begin
                fsr_d = fsr_q;
                if (wr_en_i) begin
                    fsr_d = wr_data_i;
                end else if (load_i) begin
                    fsr_d[LSB +: BANK_W] = bank_i;
                end
            end
        end else begin : g_small
            localparam int LSB = bank_lsb(1'b0);
            always_comb begin
                fsr_d = fsr_q;
                if (wr_en_i) begin
                    fsr_d = wr_data_i;
                end else if (load_i) begin
                    fsr_d[LSB +: BANK_W] = bank_i;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            fsr_q <= '0;
        end else begin
            fsr_q <= fsr_d;
        end
    end

    assign fsr_o = fsr_q;

endmodule

// File: rtl/bank_sel_unit.sv
module bank_sel_unit
    import bsel_pkg::*;
#(
    parameter bit LARGE_MEM = 1'b1,
    parameter int CYC_W     = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             instr_vld,
    input  logic [11:0]      instr,
    input  logic             skip_req,
    input  logic             fsr_wr_en,
    input  logic [7:0]       fsr_wr_data,
    output logic [7:0]       fsr,
    output logic             annul,
    output logic             busy,
    output logic             skip_done,
    output logic [CYC_W-1:0] skip_cycles
);

    dec_t dec;
    logic load_bank;

    bsel_decode u_dec (
        .instr_i (instr),
        .dec_o   (dec)
    );

    bsel_skip_track #(.CYC_W(CYC_W)) u_trk (
        .clk       (clk),
        .rst       (rst),
        .vld_i     (instr_vld),
        .skip_i    (skip_req),
        .is_bank_i (dec.is_bank),
        .annul_o   (annul),
        .busy_o    (busy),
        .done_o    (skip_done),
        .cyc_o     (skip_cycles)
    );

    assign load_bank = instr_vld & ~annul & dec.is_bank;

    bsel_fsr_reg #(.LARGE_MEM(LARGE_MEM)) u_fsr (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (fsr_wr_en),
        .wr_data_i (fsr_wr_data),
        .load_i    (load_bank),
        .bank_i    (dec.bank),
        .fsr_o     (fsr)
    );

endmodule

// File: rtl/bsel_chk.sv
module bsel_chk
    import bsel_pkg::*;
#(
    parameter bit LARGE_MEM = 1'b1,
    parameter int CYC_W     = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             instr_vld,
    input logic [11:0]      instr,
    input logic             skip_req,
    input logic             fsr_wr_en,
    input logic [7:0]       fsr_wr_data,
    input logic [7:0]       fsr,
    input logic             annul,
    input logic             busy,
    input logic             skip_done,
    input logic [CYC_W-1:0] skip_cycles
);

    localparam int   LSB  = bank_lsb(LARGE_MEM);
    localparam fsr_t KEEP = keep_mask(LARGE_MEM);

    logic word_is_bank;
    assign word_is_bank = decode_word(instr).is_bank;

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (fsr == 8'h00 && !busy));                                   // R10

    AST_NON_BANK_STABLE: assert property (@(posedge clk) disable iff (rst)
        instr_vld && !word_is_bank && !fsr_wr_en |=> $stable(fsr));        // R1

    AST_BANK_FIELD: assert property (@(posedge clk) disable iff (rst)
        instr_vld && !annul && word_is_bank && !fsr_wr_en
        |=> fsr[LSB +: BANK_W] == $past(instr[BANK_W-1:0]));                // R2, R3

    AST_KEEP_BITS: assert property (@(posedge clk) disable iff (rst)
        !fsr_wr_en |=> (fsr & KEEP) == ($past(fsr) & KEEP));                // R2, R3

    AST_SKIP_ANNUL: assert property (@(posedge clk) disable iff (rst)
        instr_vld && skip_req |-> annul);                                   // R5

    AST_FIRST_COUNT: assert property (@(posedge clk) disable iff (rst)
        skip_done && !busy |-> skip_cycles == CYC_W'(2));                   // R5

    AST_DONE_ANNUL: assert property (@(posedge clk) disable iff (rst)
        skip_done |-> annul && !word_is_bank);                              // R6

    AST_CHAIN_BUSY: assert property (@(posedge clk) disable iff (rst)
        instr_vld && annul && word_is_bank |=> busy);                       // R7

    AST_ANNUL_HOLD: assert property (@(posedge clk) disable iff (rst)
        instr_vld && annul && !fsr_wr_en |=> $stable(fsr));                // R8

    AST_CHAIN_CLEAR: assert property (@(posedge clk) disable iff (rst)
        skip_done |=> !busy);                                               // R8

    AST_WR_PRIORITY: assert property (@(posedge clk) disable iff (rst)
        fsr_wr_en |=> fsr == $past(fsr_wr_data));                           // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !instr_vld |-> !annul && !skip_done);                               // R11

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !instr_vld |=> busy == $past(busy));                                // R11

endmodule

bind bank_sel_unit bsel_chk #(.LARGE_MEM(LARGE_MEM), .CYC_W(CYC_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .instr_vld   (instr_vld),
    .instr       (instr),
    .skip_req    (skip_req),
    .fsr_wr_en   (fsr_wr_en),
    .fsr_wr_data (fsr_wr_data),
    .fsr         (fsr),
    .annul       (annul),
    .busy        (busy),
    .skip_done   (skip_done),
    .skip_cycles (skip_cycles)
);

// File: tb/bank_sel_unit_test.sv
module bank_sel_unit_test;

    localparam int CYC_W = 4;
    localparam int CMAX  = (1 << CYC_W) - 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             instr_vld = 1'b0;
    logic [11:0]      instr = '0;
    logic             skip_req = 1'b0;
    logic             fsr_wr_en = 1'b0;
    logic [7:0]       fsr_wr_data = '0;

    logic [7:0]       fsr_l, fsr_s;
    logic             annul_l, annul_s, busy_l, busy_s, done_l, done_s;
    logic [CYC_W-1:0] cyc_l, cyc_s;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // reference model state
    logic [7:0] m_fsr_l, m_fsr_s;
    bit         m_pend;
    int         m_cnt;

    always #4 clk = ~clk;

    bank_sel_unit #(.LARGE_MEM(1'b1), .CYC_W(CYC_W)) uut (
        .clk(clk), .rst(rst), .instr_vld(instr_vld), .instr(instr),
        .skip_req(skip_req), .fsr_wr_en(fsr_wr_en), .fsr_wr_data(fsr_wr_data),
        .fsr(fsr_l), .annul(annul_l), .busy(busy_l), .skip_done(done_l),
        .skip_cycles(cyc_l)
    );

    bank_sel_unit #(.LARGE_MEM(1'b0), .CYC_W(CYC_W)) uut_small (
        .clk(clk), .rst(rst), .instr_vld(instr_vld), .instr(instr),
        .skip_req(skip_req), .fsr_wr_en(fsr_wr_en), .fsr_wr_data(fsr_wr_data),
        .fsr(fsr_s), .annul(annul_s), .busy(busy_s), .skip_done(done_s),
        .skip_cycles(cyc_s)
    );

    task automatic check(input string tag, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, got, exp, $time);
        end
    endtask

    task automatic step(input string tag, input bit r, input bit v, input logic [11:0] w,
                        input bit sk, input bit we, input logic [7:0] wd);
        bit isb, ann, done;
        int cur, n;
        @(negedge clk);
        rst = r; instr_vld = v; instr = w; skip_req = sk;
        fsr_wr_en = we; fsr_wr_data = wd;
        #1;
        isb  = (w[11:3] == 9'd3);
        n    = int'(w[2:0]);
        ann  = v && (sk || m_pend);
        cur  = m_pend ? ((m_cnt >= CMAX) ? CMAX : m_cnt + 1) : 2;
        done = ann && !isb;
        check(tag, "fsr_large", fsr_l, m_fsr_l);
        check(tag, "fsr_small", fsr_s, m_fsr_s);
        check(tag, "annul", annul_l, ann);
        check(tag, "annul_small", annul_s, ann);
        check(tag, "busy", busy_l, m_pend);
        check(tag, "skip_done", done_l, done);
        if (done) check(tag, "skip_cycles", cyc_l, cur);
        if (r) begin
            m_fsr_l = 8'h00; m_fsr_s = 8'h00; m_pend = 1'b0; m_cnt = 0;
        end else begin
            if (ann && isb) begin
                m_pend = 1'b1; m_cnt = cur;
            end else if (ann) begin
                m_pend = 1'b0; m_cnt = 0;
            end
            if (we) begin
                m_fsr_l = wd; m_fsr_s = wd;
            end else if (v && !ann && isb) begin
                m_fsr_l = (m_fsr_l & 8'h8F) | 8'(n << 4);
                m_fsr_s = (m_fsr_s & 8'h1F) | 8'(n << 5);
            end
        end
    endtask

    function automatic logic [11:0] bank_op(input int n);
        return 12'h018 | 12'(n & 7);
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        m_fsr_l = 8'h00; m_fsr_s = 8'h00; m_pend = 1'b0; m_cnt = 0;
        // R10: reset state, including reset in the middle of a chain
        step("R10", 1, 0, 12'h000, 0, 0, 8'h00);
        step("R10", 1, 0, 12'h000, 0, 0, 8'h00);
        step("R10", 0, 0, 12'h000, 0, 0, 8'h00);
        step("R10", 0, 1, 12'h000, 0, 1, 8'hFF);
        step("R10", 0, 1, bank_op(2), 1, 0, 8'h00);
        step("R10", 1, 0, 12'h000, 0, 0, 8'h00);
        step("R10", 0, 0, 12'h000, 0, 0, 8'h00);

        // R2 / R3: every bank number over two background values
        for (int pre = 0; pre < 2; pre++) begin
            for (int n = 0; n < 8; n++) begin
                step("R9", 0, 1, 12'h000, 0, 1, pre ? 8'hFF : 8'h00);
                step("R2", 0, 1, bank_op(n), 0, 0, 8'h00);
                step("R3", 0, 0, 12'h000, 0, 0, 8'h00);
            end
        end
        // R2: bank 7 sets bits 6:4 to 111
        step("R9", 0, 1, 12'h000, 0, 1, 8'h00);
        step("R2", 0, 1, bank_op(7), 0, 0, 8'h00);
        step("R2", 0, 0, 12'h000, 0, 0, 8'h00);
        check("R2", "bank7_field", int'(fsr_l[6:4]), 7);

        // R4: unskipped bank-load is a single cycle
        step("R4", 0, 1, bank_op(5), 0, 0, 8'h00);
        step("R4", 0, 1, 12'h000, 0, 0, 8'h00);

        // R1: every 12-bit word, no skip
        for (int w = 0; w < 4096; w++) begin
            step("R1", 0, 1, 12'(w), 0, 0, 8'h00);
        end

        // R5: skip on a plain word
        step("R5", 0, 1, 12'hA55, 1, 0, 8'h00);
        step("R5", 0, 1, 12'h000, 0, 0, 8'h00);

        // R6: skip on one bank-load
        step("R9", 0, 1, 12'h000, 0, 1, 8'h0F);
        step("R6", 0, 1, bank_op(6), 1, 0, 8'h00);
        step("R6", 0, 1, 12'h123, 0, 0, 8'h00);
        step("R6", 0, 1, 12'h000, 0, 0, 8'h00);

        // R7: chains of every length, past saturation
        for (int k = 1; k <= 16; k++) begin
            step("R7", 0, 1, bank_op(k), 1, 0, 8'h00);
            for (int j = 1; j < k; j++) step("R7", 0, 1, bank_op(j + 3), 0, 0, 8'h00);
            step("R7", 0, 1, 12'h7FF, 0, 0, 8'h00);
        end

        // R8: annulled loads leave fsr; next load executes
        step("R9", 0, 1, 12'h000, 0, 1, 8'h33);
        step("R8", 0, 1, bank_op(7), 1, 0, 8'h00);
        step("R8", 0, 1, bank_op(0), 0, 0, 8'h00);
        step("R8", 0, 1, 12'hFFF, 0, 0, 8'h00);
        step("R8", 0, 1, bank_op(4), 0, 0, 8'h00);
        step("R8", 0, 1, 12'h000, 0, 0, 8'h00);

        // R9: direct write beats a bank-load, also mid-chain
        step("R9", 0, 1, bank_op(7), 0, 1, 8'h80);
        step("R9", 0, 1, bank_op(1), 1, 1, 8'h01);
        step("R9", 0, 1, 12'h000, 0, 0, 8'h00);

        // R11: no valid word: skip ignored, chain held across gaps
        step("R11", 0, 0, bank_op(3), 1, 0, 8'h00);
        step("R11", 0, 1, 12'h000, 0, 0, 8'h00);
        step("R11", 0, 1, bank_op(3), 1, 0, 8'h00);
        step("R11", 0, 0, 12'h000, 0, 0, 8'h00);
        step("R11", 0, 0, bank_op(2), 0, 0, 8'h00);
        step("R11", 0, 1, 12'h0F0, 0, 0, 8'h00);

        // mixed random traffic against the model
        for (int i = 0; i < 3000; i++) begin
            automatic int  r  = int'($urandom_range(0, 99));
            automatic bit  v  = (r < 90);
            automatic bit  sk = v && ($urandom_range(0, 3) == 0);
            automatic bit  we = ($urandom_range(0, 9) == 0);
            automatic logic [11:0] w = ($urandom_range(0, 1) == 1) ?
                                       bank_op(int'($urandom_range(0, 7))) :
                                       12'($urandom_range(0, 4095));
            step("R7", 0, v, w, sk, we, 8'($urandom_range(0, 255)));
        end

        finish_run();
    end

endmodule